// File: doc/BRIEF.md
# Traceback Survivor Unit for a Viterbi Decoder

This block holds the survivor decisions of an eight-state Viterbi decoder and turns them back into decoded data. Each trellis step it receives a vector with one decision bit per state and the index of the state currently holding the lowest path metric. The vector is written into a circular decision memory. Each column of that memory is one trellis step, and each row is one state.

A traceback walks backwards through that memory. At each column it reads the decision of the state it currently sits in, and it forms the predecessor state by shifting the state left with that bit entering at the bottom. Once enough steps are collected, a traceback starts at the reported best state. It walks a fixed depth without producing output, so that the path has time to merge with the survivor. It then recovers one block of the oldest bits on the path. Those bits appear newest first, so they are pushed onto a stack and popped out in time order.

When the encoder has ended a frame with zero tail bits, the last step of the frame is flagged. The unit then traces from state zero and drains every step of the frame that is still outstanding.

Top module: `tbsu_traceback`

## Requirements
- R1: While reset is held, and after it until a traceback has finished, `out_valid` stays low.
- R2: A step is stored only when `in_valid` is high, and `in_dec` is ignored otherwise. Bit `s` of `in_dec` is the decision of state `s`. The predecessor of state `s` is `{s[1:0], in_dec[s]}`, and the data bit that led into `s` is `s[2]`.
- R3: When a step brings the count of steps not yet given to any traceback to `TB_DEPTH+BLK_LEN` (32), a traceback begins at that step's column from state `in_best`. It passes `TB_DEPTH` (24) steps without output and then recovers the next `BLK_LEN` (8) bits.
- R4: The decoded stream gives the data bits of a frame in the order in which their steps were written.
- R5: Every step of a frame, including the zero tail, produces exactly one output bit. No bit is lost or repeated.
- R6: On a step with `in_last` high, `in_best` is ignored. A traceback starts from state 0 at that column and recovers all outstanding steps of the frame with no skipped depth.
- R7: When the flagged last step is also the step that completes 32 outstanding steps, only the frame-end traceback runs, and it emits all 32 bits.
- R8: The bits of one traceback leave on consecutive cycles. In a frame longer than 32 steps, the first burst of `out_valid` lasts exactly `BLK_LEN` cycles. In a shorter frame, it lasts the whole frame length.
- R9: The reordering stack never takes a push when full and never takes a pop when empty.
- R10: The decision memory wraps around, so frames longer than its 64 columns decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A trellis step is presented this cycle |
| in_dec | input | 8 | Per-state decision bits for the step |
| in_best | input | 3 | Index of the state with the lowest path metric |
| in_last | input | 1 | Final step of a zero-terminated frame |
| out_valid | output | 1 | A decoded bit is present |
| out_bit | output | 1 | Decoded data bit, in time order |

## Verification
The bench builds the unit with its default parameters: 8 states, a depth of 24, blocks of 8 and 64 memory columns. Under these values a sweep of frame lengths from 3 to 48 steps is short enough to be exhaustive. It reaches frames that end before the first periodic traceback, a frame that ends exactly on the 32-step boundary, frames ending one step past a boundary, and frames with several periodic blocks. Two frames of 100 and 153 steps wrap the 64-column memory. Garbage on the final step's best-state input shows that the frame-end traceback ignores it.

// File: rtl/tbsu_pkg.sv
// Shared types for the traceback survivor unit.
package tbsu_pkg;

    // Phase of the traceback walker.
    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_SKIP,
        WALK_EMIT
    } walk_phase_e;

endpackage

// File: rtl/tbsu_dec_mem.sv
// Decision memory: one column per trellis step, one row (bit) per state.
// Assumes the column count is a power of two so addresses wrap naturally.
// Read is combinational; write happens on the clock edge.
module tbsu_dec_mem #(
    parameter int ROWS   = 8,
    parameter int COL_AW = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [COL_AW-1:0] wr_col,
    input  logic [ROWS-1:0]   wr_vec,
    input  logic [COL_AW-1:0] rd_col,
    output logic [ROWS-1:0]   rd_vec
);
    localparam int COLS = 1 << COL_AW;

    logic [ROWS-1:0] cols_q [COLS];

    // Store the decision vector of the current step in its column.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cols_q[wr_col] <= wr_vec;
        end
    end

    assign rd_vec = cols_q[rd_col];

endmodule

// File: rtl/tbsu_walker.sv
// Traceback walker: starting from a given column and state, steps backwards
// one column per cycle. The predecessor state is formed by shifting the
// state left with the decision bit entering at the LSB. The first skip_len
// steps produce nothing. The next emit_len steps push the state's MSB
// (the data bit of that step). Assumes emit_len is non-zero when started.
module tbsu_walker
    import tbsu_pkg::*;
#(
    parameter int SW     = 3,
    parameter int COL_AW = 6,
    parameter int NW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_AW-1:0] start_col,
    input  logic [SW-1:0]     start_state,
    input  logic [NW-1:0]     skip_len,
    input  logic [NW-1:0]     emit_len,
    output logic [COL_AW-1:0] rd_col,
    input  logic [(1<<SW)-1:0] rd_vec,
    output logic              busy,
    output logic              push,
    output logic              push_bit
);
    walk_phase_e       phase_q;
    logic [COL_AW-1:0] col_q;
    logic [SW-1:0]     st_q;
    logic [NW-1:0]     skip_q;
    logic [NW-1:0]     emit_q;
    logic [SW-1:0]     st_prev;

    // Predecessor state from the decision stored for the current state.
    always_comb begin
        st_prev = {st_q[SW-2:0], rd_vec[st_q]};
    end

    // Walk control: load a job, skip the merge depth, then emit bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= WALK_IDLE;
            col_q   <= '0;
            st_q    <= '0;
            skip_q  <= '0;
            emit_q  <= '0;
        end else begin
            case (phase_q)
                WALK_IDLE: begin
                    if (start) begin
                        col_q   <= start_col;
                        st_q    <= start_state;
                        skip_q  <= skip_len;
                        emit_q  <= emit_len;
                        phase_q <= (skip_len != '0) ? WALK_SKIP : WALK_EMIT;
                    end
                end
                WALK_SKIP: begin
                    col_q  <= col_q - COL_AW'(1);
                    st_q   <= st_prev;
                    skip_q <= skip_q - NW'(1);
                    if (skip_q == NW'(1)) begin
                        phase_q <= WALK_EMIT;
                    end
                end
                WALK_EMIT: begin
                    col_q  <= col_q - COL_AW'(1);
                    st_q   <= st_prev;
                    emit_q <= emit_q - NW'(1);
                    if (emit_q == NW'(1)) begin
                        phase_q <= WALK_IDLE;
                    end
                end
                default: phase_q <= WALK_IDLE;
            endcase
        end
    end

    assign rd_col   = col_q;
    assign busy     = (phase_q != WALK_IDLE);
    assign push     = (phase_q == WALK_EMIT);
    assign push_bit = st_q[SW-1];

    // R3: after the last skipped step the walker turns to emitting.
    p_skip_then_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == WALK_SKIP && skip_q == NW'(1)) |=> (phase_q == WALK_EMIT));

    // R6: a job with no skip depth emits from its very first step.
    p_final_no_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && skip_len == '0) |=> (phase_q == WALK_EMIT));

    // R5: the walker returns to idle after its last emitted bit.
    p_emit_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == WALK_EMIT && emit_q == NW'(1)) |=> (phase_q == WALK_IDLE));

endmodule

// File: rtl/tbsu_lifo.sv
// Single-bit stack that restores time order of the traced bits.
// Assumes push and pop are never requested together.
module tbsu_lifo #(
    parameter int DEPTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_bit,
    input  logic pop,
    output logic top_bit,
    output logic empty
);
    localparam int AW    = $clog2(DEPTH + 1);
    localparam int SLOTS = 1 << AW;

    logic [SLOTS-1:0] bits_q;
    logic [AW-1:0]    cnt_q;

    // Fill level of the stack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push) begin
            cnt_q <= cnt_q + AW'(1);
        end else if (pop) begin
            cnt_q <= cnt_q - AW'(1);
        end
    end

    // Bit storage, written at the current fill level.
    always_ff @(posedge clk) begin
        if (push) begin
            bits_q[cnt_q] <= push_bit;
        end
    end

    assign top_bit = bits_q[cnt_q - AW'(1)];
    assign empty   = (cnt_q == '0);

    // R9: no push into a full stack.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q < AW'(DEPTH)));

    // R9: no pop from an empty stack.
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));

endmodule

// File: rtl/tbsu_traceback.sv
// Traceback survivor unit. It stores the per-step decision vectors and
// schedules tracebacks. A periodic traceback runs from the best state each
// time TB_DEPTH+BLK_LEN steps are outstanding. A frame-end traceback runs
// from state 0 on the flagged last step. Decoded bits are reordered
// through a stack.
// Assumes the encoder ends each frame with K-1 zero bits, and that steps
// arrive slowly enough for one traceback to finish before the one after
// the next is scheduled.
module tbsu_traceback #(
    parameter int K        = 4,
    parameter int TB_DEPTH = 24,
    parameter int BLK_LEN  = 8,
    parameter int COL_AW   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [(1<<(K-1))-1:0] in_dec,
    input  logic [K-2:0]       in_best,
    input  logic               in_last,
    output logic               out_valid,
    output logic               out_bit
);
    localparam int SW   = K - 1;
    localparam int NS   = 1 << SW;
    localparam int SPAN = TB_DEPTH + BLK_LEN;
    localparam int NW   = $clog2(SPAN + 1);
    localparam int COLS = 1 << COL_AW;

    // Memory must hold the traced span plus the steps written meanwhile.
    initial assert (COLS >= SPAN + 2 * BLK_LEN);

    logic [COL_AW-1:0] wr_col_q;
    logic [NW-1:0]     open_q;
    logic              job_v_q;
    logic [COL_AW-1:0] job_col_q;
    logic [SW-1:0]     job_state_q;
    logic [NW-1:0]     job_skip_q;
    logic [NW-1:0]     job_emit_q;
    logic              job_new;
    logic              job_take;
    logic [COL_AW-1:0] rd_col;
    logic [NS-1:0]     rd_vec;
    logic              walk_busy;
    logic              push;
    logic              push_bit;
    logic              pop;
    logic              top_bit;
    logic              lifo_empty;
    logic              out_valid_q;
    logic              out_bit_q;

    // Schedule a job on the frame end or when a full span is outstanding.
    always_comb begin
        job_new  = in_valid && (in_last || open_q == NW'(SPAN - 1));
        job_take = job_v_q && !walk_busy && lifo_empty;
        pop      = !walk_busy && !lifo_empty;
    end

    // Write pointer and count of steps not yet given to a traceback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_col_q <= '0;
            open_q   <= '0;
        end else if (in_valid) begin
            wr_col_q <= wr_col_q + COL_AW'(1);
            if (in_last) begin
                open_q <= '0;
            end else if (open_q == NW'(SPAN - 1)) begin
                open_q <= NW'(TB_DEPTH);
            end else begin
                open_q <= open_q + NW'(1);
            end
        end
    end

    // One-entry job holder between the scheduler and the walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_v_q     <= 1'b0;
            job_col_q   <= '0;
            job_state_q <= '0;
            job_skip_q  <= '0;
            job_emit_q  <= '0;
        end else if (job_new) begin
            job_v_q     <= 1'b1;
            job_col_q   <= wr_col_q;
            job_state_q <= in_last ? '0 : in_best;
            job_skip_q  <= in_last ? '0 : NW'(TB_DEPTH);
            job_emit_q  <= in_last ? open_q + NW'(1) : NW'(BLK_LEN);
        end else if (job_take) begin
            job_v_q     <= 1'b0;
        end
    end

    tbsu_dec_mem #(
        .ROWS   (NS),
        .COL_AW (COL_AW)
    ) mem_i (
        .clk    (clk),
        .wr_en  (in_valid),
        .wr_col (wr_col_q),
        .wr_vec (in_dec),
        .rd_col (rd_col),
        .rd_vec (rd_vec)
    );

    tbsu_walker #(
        .SW     (SW),
        .COL_AW (COL_AW),
        .NW     (NW)
    ) walk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (job_take),
        .start_col   (job_col_q),
        .start_state (job_state_q),
        .skip_len    (job_skip_q),
        .emit_len    (job_emit_q),
        .rd_col      (rd_col),
        .rd_vec      (rd_vec),
        .busy        (walk_busy),
        .push        (push),
        .push_bit    (push_bit)
    );

    tbsu_lifo #(
        .DEPTH (SPAN)
    ) lifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_bit (push_bit),
        .pop      (pop),
        .top_bit  (top_bit),
        .empty    (lifo_empty)
    );

    // Registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_bit_q   <= 1'b0;
        end else begin
            out_valid_q <= pop;
            out_bit_q   <= top_bit;
        end
    end

    assign out_valid = out_valid_q;
    assign out_bit   = out_bit_q;

    // R6: a flagged last step queues a job that starts from state 0.
    p_last_from_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (job_v_q && job_state_q == '0 && job_skip_q == '0));

    // R5: a new job never overwrites one still waiting for the walker.
    p_job_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        job_new |-> !(job_v_q && !job_take));

    // R8: no output is produced while a traceback walk is in progress.
    p_quiet_while_walking_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(walk_busy) |-> !out_valid);

endmodule

// File: tb/tbsu_traceback_tb.sv
// Bench: sweeps zero-terminated frames of many lengths. It builds decision
// vectors that hold a known survivor path and compares the decoded stream.
module tbsu_traceback_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int K          = 4;
    localparam int TB_DEPTH   = 24;
    localparam int BLK_LEN    = 8;
    localparam int SW         = K - 1;
    localparam int NS         = 1 << SW;
    localparam int SPAN       = TB_DEPTH + BLK_LEN;
    localparam int GAP        = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NS-1:0] in_dec = '0;
    logic [SW-1:0] in_best = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_bit;

    int   n_run = 0;
    int   n_fail = 0;
    bit   exp_bits [0:1023];
    int   exp_len = 0;
    int   rd_idx = 0;
    int   cur_run = 0;
    int   first_run = 0;
    bit   run_done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tbsu_traceback #(
        .K        (K),
        .TB_DEPTH (TB_DEPTH),
        .BLK_LEN  (BLK_LEN),
        .COL_AW   (6)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dec    (in_dec),
        .in_best   (in_best),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    task automatic adv_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Output monitor: R4 order (via R2 storage, R3 start), R5 extras, R8 burst.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                n_run++;
                if (rd_idx >= exp_len) begin
                    n_fail++;
                    $display("FAIL R5: extra bit index %0d, actual %0d expected none (frame %0d)",
                             rd_idx, out_bit, exp_len);
                end else if (out_bit !== exp_bits[rd_idx]) begin
                    n_fail++;
                    $display("FAIL R4 (R2,R3): bit %0d of %0d actual %0d expected %0d",
                             rd_idx, exp_len, out_bit, exp_bits[rd_idx]);
                end
                rd_idx++;
                cur_run++;
            end else if (cur_run != 0 && !run_done) begin
                first_run = cur_run;
                run_done  = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Drive one frame: d data bits then SW zero tail bits.
    task automatic run_frame(input int d, input bit garbage_last);
        int            len;
        logic [SW-1:0] st;
        int            exp_run;
        len       = d + SW;
        st        = '0;
        exp_len   = len;
        rd_idx    = 0;
        cur_run   = 0;
        first_run = 0;
        run_done  = 1'b0;
        for (int t = 0; t < len; t++) begin
            bit            u;
            logic [SW-1:0] nx;
            logic [NS-1:0] dv;
            u = (t < d) ? lfsr[0] : 1'b0;
            adv_lfsr();
            nx = {u, st[SW-1:1]};
            dv = lfsr[NS-1:0];
            adv_lfsr();
            dv[nx] = st[0];
            exp_bits[t] = u;
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_dec   = dv;
            in_last  = (t == len - 1);
            in_best  = (t == len - 1 && garbage_last) ? ~nx : nx;
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_last  = 1'b0;
            in_dec   = ~dv;   // R2: junk while not valid must be ignored
            in_best  = ~nx;
            repeat (GAP - 2) @(posedge clk);
            st = nx;
        end
        while (rd_idx < len) @(posedge clk);
        repeat (100) @(posedge clk);
        // R5: exactly one bit per step
        check(rd_idx == len, "R5 bit count", rd_idx, len);
        // R8 burst length; R7 when frame end meets the span boundary
        exp_run = (len > SPAN) ? BLK_LEN : len;
        if (len == SPAN) check(first_run == exp_run, "R7 single final burst", first_run, exp_run);
        else             check(first_run == exp_run, "R8 first burst", first_run, exp_run);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (20) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        // Sweep of lengths 3..48; odd d puts garbage on in_best at the end (R6).
        for (int d = 0; d <= 45; d++) begin
            run_frame(d, d[0]);
        end
        // R10: frames longer than the 64 memory columns
        run_frame(97, 1'b1);
        run_frame(150, 1'b0);
        // R9 is guarded by the stack assertions during all frames above.
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule